// File: doc/BRIEF.md
# Halfword store address generator

This block turns one 32-bit store-halfword instruction word into a single halfword write request for memory. It decodes the word, reads a base register and an offset from one of two register files, scales the offset to halfword units and forms the effective address with one of six addressing options. Those options are negative or positive offset, pre-decrement, pre-increment, post-decrement and post-increment. The modifying options also return an updated base value to the register file. The low 16 bits of a source register, which may sit in either file, are placed on the matching byte lanes of a 32-bit write bus.

The block drives the three register indices straight from the instruction fields. The surrounding register files answer in the same cycle on six read-data inputs, three per file. An accepted instruction is registered once. The request and the write-back are presented for exactly one cycle after the clock edge that took the instruction. A small state machine classifies that cycle. ST_IDLE means no request. ST_STORE means a valid write and, when the mode modifies the base, a write-back. ST_FAULT means the address was odd, and neither write is made. Every state moves on each clock edge. It goes to ST_STORE when a well-formed instruction is offered with an even address, to ST_FAULT when the instruction is well-formed but the address is odd, and to ST_IDLE otherwise.

Address arithmetic wraps modulo 2^32 unless circular mode is turned on for the base register in use. Circular mode is available only for registers 4 to 7 of either file. Under circular mode the modified address stays inside an aligned block of 2^(N+1) bytes.

Top module: `hstore_agu`

## Requirements
- R1: An instruction is accepted only when in_valid is high, bit 8 is 0, bits 6..2 equal 10101, and the 4-bit mode field at bits 12..9 holds one of the twelve codes listed in R5 and R6. Any other word, including mode codes 0010, 0011, 0110 and 0111, produces no write request, no fault and no write-back.
- R2: Instruction bit 7 (y) selects the register file for the base and the offset register: 0 selects file A and 1 selects file B. The write-back goes to that same file (wb_file equals y), at the index held in bits 22..18.
- R3: Instruction bit 1 (s) selects the file that supplies the data, independent of y: 0 selects file A and 1 selects file B. The source index is bits 27..23.
- R4: Mode bit 2 (instruction bit 11) chooses the offset: 0 takes the 5-bit constant at bits 17..13, zero-extended, and 1 takes the offset register indexed by the same bits. The offset is shifted left by one before use.
- R5: The mode codes 0000 and 0100 (negative offset), 0001 and 0101 (positive offset), 1000 and 1100 (pre-decrement), and 1001 and 1101 (pre-increment) send the base minus or plus the scaled offset to memory as the address.
- R6: The mode codes 1010 and 1110 (post-decrement) and 1011 and 1111 (post-increment) send the unmodified base to memory as the address. The modified value appears only on wb_data.
- R7: The write-back is asserted only for mode codes with bit 3 set (pre- and post-modify), and then carries the modified base. Offset modes never write back.
- R8: Circular mode applies only when the base index is 4..7. Slot k = 4*y + (base index - 4) takes its enable from mode_ctl bit 6k+5 and N from bits 6k+4..6k. When it is enabled, address bits N..0 come from the modified value and the bits above come from the unmodified base. Every other case wraps linearly modulo 2^32.
- R9: On a write, address bit 1 = 0 gives mem_wdata = {16'h0, src[15:0]} with mem_be = 0011, and address bit 1 = 1 gives mem_wdata = {src[15:0], 16'h0} with mem_be = 1100.
- R10: An accepted instruction whose address has bit 0 set raises mem_misalign for one cycle, with mem_we and wb_en held low.
- R11: Reset clears mem_we, mem_misalign and wb_en. A request, a fault or a write-back appears exactly one cycle after the edge that accepted the instruction and lasts for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is offered this cycle |
| instr | input | 32 | Store-halfword instruction word |
| rd_base_idx | output | 5 | Base register index sent to both files |
| rd_off_idx | output | 5 | Offset register index sent to both files |
| rd_src_idx | output | 5 | Source register index sent to both files |
| a_base_q | input | 32 | File A read data at rd_base_idx |
| a_off_q | input | 32 | File A read data at rd_off_idx |
| a_src_q | input | 32 | File A read data at rd_src_idx |
| b_base_q | input | 32 | File B read data at rd_base_idx |
| b_off_q | input | 32 | File B read data at rd_off_idx |
| b_src_q | input | 32 | File B read data at rd_src_idx |
| mode_ctl | input | 48 | Circular slot enables and block sizes (R8) |
| mem_we | output | 1 | Halfword write request |
| mem_misalign | output | 1 | Odd address fault |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_be | output | 4 | Byte enables |
| wb_en | output | 1 | Base register write-back |
| wb_file | output | 1 | Write-back file, 0 = A, 1 = B |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Updated base value |

## Verification
The bench builds the block at its defaults: a 32-bit datapath with circular slots on registers 4 to 7 of both files, eight slots in all. At these values both halfword lanes, every one of the twelve mode codes, and every circular slot can be reached. So can block sizes from N = 0 up to N = 31, where the block covers the whole address space and circular mode behaves linearly. Random base values, offsets, control words and malformed encodings are mixed with directed cases at the linear wrap boundary, the largest constant offset and a circular wrap on a file B register.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int IW = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_FAULT = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic       legal;
        logic       use_reg;
        logic       add;
        logic       post;
        logic       wb;
        logic       y;
        logic       s;
        logic [4:0] base_idx;
        logic [4:0] off_idx;
        logic [4:0] src_idx;
    } hs_dec_t;

endpackage

// File: rtl/hs_decode.sv
module hs_decode
    import hs_pkg::*;
(
    input  logic [IW-1:0] instr,
    output hs_dec_t       dec
);

    logic [3:0] mcode;
    logic       fmt_ok;
    logic       mode_ok;
    logic       unused_bits;

    assign unused_bits = ^{instr[31:28], instr[0]};
    assign mcode       = instr[12:9];
    assign fmt_ok      = (instr[6:2] == 5'b10101) && !instr[8];

    always_comb begin
        mode_ok = 1'b0;
        if (!mcode[3] && !mcode[1]) begin
            mode_ok = 1'b1;
        end else if (mcode[3]) begin
            mode_ok = 1'b1;
        end
    end

    always_comb begin
        dec          = '0;
        dec.legal    = fmt_ok && mode_ok;
        dec.use_reg  = mcode[2];
        dec.add      = mcode[0];
        dec.post     = mcode[3] && mcode[1];
        dec.wb       = mcode[3];
        dec.y        = instr[7];
        dec.s        = instr[1];
        dec.src_idx  = instr[27:23];
        dec.base_idx = instr[22:18];
        dec.off_idx  = instr[17:13];
    end

endmodule

// File: rtl/hs_addr_calc.sv
module hs_addr_calc #(
    parameter int XLEN       = 32,
    parameter int N_W        = 5,
    parameter int CIRC_FIRST = 4,
    parameter int CIRC_SLOTS = 4
) (
    input  logic [XLEN-1:0]                  base,
    input  logic [XLEN-1:0]                  off_raw,
    input  logic                             add,
    input  logic                             post,
    input  logic                             y,
    input  logic [4:0]                       base_idx,
    input  logic [2*CIRC_SLOTS*(N_W+1)-1:0]  ctl,
    output logic [XLEN-1:0]                  addr,
    output logic [XLEN-1:0]                  new_base
);

    localparam int SLOT_W = N_W + 1;
    localparam int NSLOT  = 2 * CIRC_SLOTS;

    logic [NSLOT-1:0] slot_en;
    logic [N_W-1:0]   slot_n [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign slot_en[k] = ctl[k*SLOT_W + N_W];
        assign slot_n[k]  = ctl[k*SLOT_W +: N_W];
    end

    logic [XLEN-1:0] scaled;
    logic [XLEN-1:0] modv;
    logic [XLEN-1:0] mask;
    logic [XLEN:0]   span;
    logic            circ_on;
    logic [N_W-1:0]  circ_n;
    int              rel;
    int              slot;

    assign scaled = {off_raw[XLEN-2:0], 1'b0};
    assign modv   = add ? (base + scaled) : (base - scaled);

    always_comb begin
        rel     = int'(base_idx) - CIRC_FIRST;
        slot    = y ? rel + CIRC_SLOTS : rel;
        circ_on = 1'b0;
        circ_n  = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (rel >= 0 && rel < CIRC_SLOTS && slot == k) begin
                circ_on = slot_en[k];
                circ_n  = slot_n[k];
            end
        end
    end

    always_comb begin
        span = (XLEN+1)'(1) << ({1'b0, circ_n} + 1'b1);
        mask = span[XLEN-1:0] - XLEN'(1);
        if (circ_on) begin
            new_base = (base & ~mask) | (modv & mask);
        end else begin
            new_base = modv;
        end
        addr = post ? base : new_base;
    end

endmodule

// File: rtl/hs_lane.sv
module hs_lane #(
    parameter int XLEN = 32
) (
    input  logic [15:0]                     half,
    input  logic [$clog2(XLEN/16)-1:0]      sel,
    output logic [XLEN-1:0]                 wdata,
    output logic [XLEN/8-1:0]               be
);

    localparam int LANES = XLEN / 16;
    localparam int SEL_W = $clog2(LANES);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wdata[l*16 +: 16] = (sel == SEL_W'(l)) ? half : 16'h0000;
        assign be[l*2 +: 2]      = (sel == SEL_W'(l)) ? 2'b11 : 2'b00;
    end

endmodule

// File: rtl/hstore_agu.sv
module hstore_agu
    import hs_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int N_W        = 5,
    parameter int CIRC_FIRST = 4,
    parameter int CIRC_SLOTS = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [31:0]                     instr,
    output logic [4:0]                      rd_base_idx,
    output logic [4:0]                      rd_off_idx,
    output logic [4:0]                      rd_src_idx,
    input  logic [XLEN-1:0]                 a_base_q,
    input  logic [XLEN-1:0]                 a_off_q,
    input  logic [XLEN-1:0]                 a_src_q,
    input  logic [XLEN-1:0]                 b_base_q,
    input  logic [XLEN-1:0]                 b_off_q,
    input  logic [XLEN-1:0]                 b_src_q,
    input  logic [2*CIRC_SLOTS*(N_W+1)-1:0] mode_ctl,
    output logic                            mem_we,
    output logic                            mem_misalign,
    output logic [XLEN-1:0]                 mem_addr,
    output logic [XLEN-1:0]                 mem_wdata,
    output logic [XLEN/8-1:0]               mem_be,
    output logic                            wb_en,
    output logic                            wb_file,
    output logic [4:0]                      wb_idx,
    output logic [XLEN-1:0]                 wb_data
);

    localparam int BE_W  = XLEN / 8;
    localparam int SEL_W = $clog2(XLEN / 16);

    hs_dec_t dec;

    hs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign rd_base_idx = dec.base_idx;
    assign rd_off_idx  = dec.off_idx;
    assign rd_src_idx  = dec.src_idx;

    logic [XLEN-1:0] base_v;
    logic [XLEN-1:0] offr_v;
    logic [XLEN-1:0] src_v;
    logic [XLEN-1:0] off_raw;
    logic            unused_src;

    assign base_v     = dec.y ? b_base_q : a_base_q;
    assign offr_v     = dec.y ? b_off_q  : a_off_q;
    assign src_v      = dec.s ? b_src_q  : a_src_q;
    assign off_raw    = dec.use_reg ? offr_v : {{(XLEN-5){1'b0}}, dec.off_idx};
    assign unused_src = ^src_v[XLEN-1:16];

    logic [XLEN-1:0] addr_c;
    logic [XLEN-1:0] new_base_c;

    hs_addr_calc #(
        .XLEN       (XLEN),
        .N_W        (N_W),
        .CIRC_FIRST (CIRC_FIRST),
        .CIRC_SLOTS (CIRC_SLOTS)
    ) u_calc (
        .base     (base_v),
        .off_raw  (off_raw),
        .add      (dec.add),
        .post     (dec.post),
        .y        (dec.y),
        .base_idx (dec.base_idx),
        .ctl      (mode_ctl),
        .addr     (addr_c),
        .new_base (new_base_c)
    );

    logic [XLEN-1:0] wdata_c;
    logic [BE_W-1:0] be_c;

    hs_lane #(.XLEN(XLEN)) u_lane (
        .half  (src_v[15:0]),
        .sel   (addr_c[SEL_W:1]),
        .wdata (wdata_c),
        .be    (be_c)
    );

    hs_state_e state_q;
    hs_state_e state_d;
    hs_state_e accept_st;
    logic      take;

    assign take = in_valid && dec.legal;

    always_comb begin
        accept_st = ST_IDLE;
        if (take) begin
            accept_st = addr_c[0] ? ST_FAULT : ST_STORE;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = accept_st;
            ST_STORE: state_d = accept_st;
            ST_FAULT: state_d = accept_st;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    logic [XLEN-1:0] addr_q;
    logic [XLEN-1:0] wdata_q;
    logic [BE_W-1:0] be_q;
    logic            wb_q;
    logic            wbf_q;
    logic [4:0]      wbi_q;
    logic [XLEN-1:0] wbd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            wb_q    <= 1'b0;
            wbf_q   <= 1'b0;
            wbi_q   <= '0;
            wbd_q   <= '0;
        end else if (take) begin
            addr_q  <= addr_c;
            wdata_q <= wdata_c;
            be_q    <= be_c;
            wb_q    <= dec.wb;
            wbf_q   <= dec.y;
            wbi_q   <= dec.base_idx;
            wbd_q   <= new_base_c;
        end
    end

    assign mem_we       = (state_q == ST_STORE);
    assign mem_misalign = (state_q == ST_FAULT);
    assign mem_addr     = addr_q;
    assign mem_wdata    = mem_we ? wdata_q : '0;
    assign mem_be       = mem_we ? be_q : '0;
    assign wb_en        = mem_we && wb_q;
    assign wb_file      = wbf_q;
    assign wb_idx       = wbi_q;
    assign wb_data      = wbd_q;

endmodule

// File: rtl/hs_agu_chk.sv
module hs_agu_chk #(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       instr,
    input logic              mem_we,
    input logic              mem_misalign,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN/8-1:0] mem_be,
    input logic              wb_en,
    input logic              wb_file,
    input logic [4:0]        wb_idx
);

    p_illegal_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (instr[6:2] != 5'b10101 || instr[8]) |=> !mem_we && !mem_misalign && !wb_en);

    p_wb_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_file == $past(instr[7]) && wb_idx == $past(instr[22:18]));

    p_offset_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !instr[12] |=> !wb_en);

    p_two_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $countones(mem_be) == 2);

    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_misalign |-> !mem_we && !wb_en);

    p_even_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_addr[0]);

    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !mem_we && !mem_misalign && !wb_en);

endmodule

bind hstore_agu hs_agu_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .instr        (instr),
    .mem_we       (mem_we),
    .mem_misalign (mem_misalign),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .wb_en        (wb_en),
    .wb_file      (wb_file),
    .wb_idx       (wb_idx)
);

// File: tb/hstore_agu_tb_top.sv
`timescale 1ns/1ps
module hstore_agu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [47:0] mode_ctl = '0;
    logic [4:0]  rd_base_idx, rd_off_idx, rd_src_idx;
    logic [31:0] a_base_q, a_off_q, a_src_q, b_base_q, b_off_q, b_src_q;
    logic        mem_we, mem_misalign, wb_en, wb_file;
    logic [31:0] mem_addr, mem_wdata, wb_data;
    logic [3:0]  mem_be;
    logic [4:0]  wb_idx;

    logic [31:0] rfa [32];
    logic [31:0] rfb [32];

    assign a_base_q = rfa[rd_base_idx];
    assign a_off_q  = rfa[rd_off_idx];
    assign a_src_q  = rfa[rd_src_idx];
    assign b_base_q = rfb[rd_base_idx];
    assign b_off_q  = rfb[rd_off_idx];
    assign b_src_q  = rfb[rd_src_idx];

    always #2.5 clk = ~clk;

    hstore_agu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rd_base_idx(rd_base_idx), .rd_off_idx(rd_off_idx), .rd_src_idx(rd_src_idx),
        .a_base_q(a_base_q), .a_off_q(a_off_q), .a_src_q(a_src_q),
        .b_base_q(b_base_q), .b_off_q(b_off_q), .b_src_q(b_src_q),
        .mode_ctl(mode_ctl),
        .mem_we(mem_we), .mem_misalign(mem_misalign), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .wb_en(wb_en), .wb_file(wb_file), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic        e_we, e_mis, e_wb, e_post;
    logic [31:0] e_addr, e_wdata, e_wbd;
    logic [3:0]  e_be;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] m, input logic y, input logic s,
                                       input logic [4:0] src, input logic [4:0] b,
                                       input logic [4:0] o);
        logic [31:0] w;
        w = '0;
        w[31:28] = 4'($urandom);
        w[27:23] = src; w[22:18] = b; w[17:13] = o; w[12:9] = m;
        w[8] = 1'b0; w[7] = y; w[6:2] = 5'b10101; w[1] = s; w[0] = 1'($urandom);
        return w;
    endfunction

    task automatic model(input logic [31:0] w, input logic [47:0] ctl);
        logic        ok, add, pre_mod, y, s, circ;
        logic [4:0]  b, o, n;
        logic [31:0] base, off, modv, res, src;
        int          k;
        ok = 1; add = 0; e_post = 0; e_wb = 0; pre_mod = 0;
        case (w[12:9])
            4'b0000, 4'b0100: add = 0;
            4'b0001, 4'b0101: add = 1;
            4'b1000, 4'b1100: begin add = 0; pre_mod = 1; end
            4'b1001, 4'b1101: begin add = 1; pre_mod = 1; end
            4'b1010, 4'b1110: begin add = 0; e_post = 1; end
            4'b1011, 4'b1111: begin add = 1; e_post = 1; end
            default: ok = 0;
        endcase
        if (w[8] || w[6:2] != 5'b10101) ok = 0;
        y = w[7]; s = w[1]; b = w[22:18]; o = w[17:13];
        base = y ? rfb[b] : rfa[b];
        off  = w[11] ? (y ? rfb[o] : rfa[o]) : {27'd0, o};
        off  = off * 2;
        modv = add ? base + off : base - off;
        circ = 0; n = 0;
        if (b >= 4 && b <= 7) begin
            k = (y ? 4 : 0) + (int'(b) - 4);
            circ = ctl[6*k+5];
            n = ctl[6*k +: 5];
        end
        res = modv;
        if (circ)
            for (int i = 0; i < 32; i++) res[i] = (i <= int'(n)) ? modv[i] : base[i];
        e_addr = e_post ? base : res;
        e_wbd  = res;
        src    = s ? rfb[w[27:23]] : rfa[w[27:23]];
        e_wdata = e_addr[1] ? {src[15:0], 16'h0} : {16'h0, src[15:0]};
        e_be    = e_addr[1] ? 4'b1100 : 4'b0011;
        e_mis  = ok && e_addr[0];
        e_we   = ok && !e_addr[0];
        e_wb   = e_we && (pre_mod || e_post);
    endtask

    task automatic run_op(input logic [31:0] w, input logic [47:0] ctl);
        @(negedge clk);
        instr = w; mode_ctl = ctl; in_valid = 1'b1;
        model(w, ctl);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 R10 mem_we", 32'(mem_we), 32'(e_we));
        chk("R10 mem_misalign", 32'(mem_misalign), 32'(e_mis));
        chk("R7 wb_en", 32'(wb_en), 32'(e_wb));
        if (e_we) begin
            chk(e_post ? "R6 address" : "R5 R4 address", mem_addr, e_addr);
            chk("R3 R9 mem_wdata", mem_wdata, e_wdata);
            chk("R9 mem_be", 32'(mem_be), 32'(e_be));
        end
        if (e_wb) begin
            chk("R6 R8 wb_data", wb_data, e_wbd);
            chk("R2 wb_file", 32'(wb_file), 32'(w[7]));
            chk("R2 wb_idx", 32'(wb_idx), 32'(w[22:18]));
        end
    endtask

    task automatic quiet_check();
        @(negedge clk);
        chk("R11 pulse mem_we", 32'(mem_we), 32'd0);
        chk("R11 pulse misalign", 32'(mem_misalign), 32'd0);
        chk("R11 pulse wb_en", 32'(wb_en), 32'd0);
    endtask

    logic [3:0] modes [12] = '{4'b0000, 4'b0001, 4'b1000, 4'b1001, 4'b1010, 4'b1011,
                               4'b0100, 4'b0101, 4'b1100, 4'b1101, 4'b1110, 4'b1111};

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) begin
            rfa[i] = $urandom; rfb[i] = $urandom;
        end
        repeat (3) @(negedge clk);
        chk("R11 reset mem_we", 32'(mem_we), 32'd0);
        chk("R11 reset misalign", 32'(mem_misalign), 32'd0);
        chk("R11 reset wb_en", 32'(wb_en), 32'd0);
        rst_n = 1'b1;

        // R4: largest constant, pre-increment, file A, linear
        rfa[3] = 32'h0000_1000;
        run_op(mk(4'b1001, 1'b0, 1'b0, 5'd9, 5'd3, 5'd31), 48'h0);
        chk("R4 literal address", mem_addr, 32'h0000_103E);

        // R5: negative register offset wraps linearly below zero
        rfb[10] = 32'h0000_0002; rfb[11] = 32'h0000_0002;
        run_op(mk(4'b0100, 1'b1, 1'b0, 5'd1, 5'd10, 5'd11), 48'h0);
        chk("R5 literal linear wrap", mem_addr, 32'hFFFF_FFFE);

        // R8: post-increment on B5, N=3, wraps in a 16-byte block
        rfb[5] = 32'h0000_200E;
        run_op(mk(4'b1011, 1'b1, 1'b1, 5'd2, 5'd5, 5'd1), 48'h0 | (48'h23 << 30));
        chk("R6 literal post address", mem_addr, 32'h0000_200E);
        chk("R8 literal circular wb", wb_data, 32'h0000_2000);

        // R8: N=31 on A4 behaves linearly; slot enabled but base A8 stays linear
        rfa[4] = 32'hFFFF_FFF0;
        run_op(mk(4'b1001, 1'b0, 1'b0, 5'd4, 5'd4, 5'd20), 48'h3F);
        chk("R8 literal full block", wb_data, 32'h0000_0018);
        rfa[8] = 32'h0000_001E;
        run_op(mk(4'b1001, 1'b0, 1'b0, 5'd4, 5'd8, 5'd1), 48'h2020_2020_2020);
        chk("R8 literal outside slots", wb_data, 32'h0000_0020);

        // R1: reserved bit set, bad pattern, bad mode code
        run_op(mk(4'b1001, 1'b0, 1'b0, 5'd1, 5'd3, 5'd1) | 32'h100, 48'h0);
        run_op(mk(4'b1001, 1'b0, 1'b0, 5'd1, 5'd3, 5'd1) ^ 32'h8, 48'h0);
        run_op(mk(4'b0110, 1'b0, 1'b0, 5'd1, 5'd3, 5'd1), 48'h0);

        // R10: odd base
        rfa[12] = 32'h0000_1001;
        run_op(mk(4'b0001, 1'b0, 1'b0, 5'd1, 5'd12, 5'd2), 48'h0);
        chk("R10 literal fault", 32'(mem_misalign), 32'd1);
        quiet_check();

        for (int t = 0; t < 600; t++) begin
            logic [31:0] w;
            logic [4:0]  b;
            logic [47:0] ctl;
            b = 5'($urandom);
            if ($urandom % 3 == 0) b = 5'(4 + $urandom % 4);
            w = mk(modes[$urandom % 12], 1'($urandom), 1'($urandom),
                   5'($urandom), b, 5'($urandom));
            case ($urandom % 12)
                0: w[8] = 1'b1;
                1: w[6:2] = 5'($urandom);
                2: w[12:9] = {1'b0, 1'($urandom), 2'b1x | 2'b10};
                default: ;
            endcase
            rfa[b] = $urandom; rfb[b] = $urandom;
            if ($urandom % 5 != 0) begin rfa[b][0] = 1'b0; rfb[b][0] = 1'b0; end
            ctl = {$urandom, $urandom};
            run_op(w, ctl);
            if ($urandom % 4 == 0) quiet_check();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule